// File: doc/BRIEF.md
# I2C Clock Phase Timer

This block produces the clock line of an I2C master. It holds SCL low for a programmed number of count-clock ticks, lets it go, waits until the sensed SCL line really reads high, and then holds the high phase for a second programmed number of ticks. Because the high phase is only timed once the line is seen high, the rise time is left out of the count and a slave that stretches the clock simply pushes the high phase back.

Each period count is nine bits wide. The lower eight bits come from their own byte inputs. The ninth bits come from a shared configuration byte: bit 7 extends the low count and bit 6 extends the high count. In 8-bit mode the shared byte is ignored and the counts top out at 0xFF. The count clock is the system clock divided by 1 or 2. A byte engine uses the one-cycle strobes at each falling edge, each rising edge and the middle of each high phase. The sensed SCL input is expected to be synchronised already.

Top module: `scl_period_gen`

## Requirements
- R1: After reset, `scl_oe`, `fall_stb`, `rise_stb` and `mid_stb` are all 0.
- R2: A low phase drives `scl_oe` for exactly L*M cycles. L is the effective low count and M is 2 when `div2`=1, otherwise 1.
- R3: After `scl_oe` drops, the block waits for `scl_in`. `rise_stb` fires in the cycle after the first cycle in which `scl_in` is sampled 1, so a release stretched by S cycles makes the wait last S+1 cycles.
- R4: The high phase lasts H*M cycles, counted from the `rise_stb` cycle to the next `fall_stb` cycle, where H is the effective high count.
- R5: With `wide_mode`=1, the low count is {`ext_bits[7]`, `lo_count`} and the high count is {`ext_bits[6]`, `hi_count`}. Each spans 0..0x1FF.
- R6: With `wide_mode`=0, `ext_bits` has no effect and each count is its 8-bit input alone.
- R7: A count value of zero acts as a count of one.
- R8: With `div2`=1 the count clock ticks on every second system cycle of a phase, which doubles every phase length.
- R9: `mid_stb` fires at offset H>>1 after `rise_stb` when `div2`=0, and at offset 2*(H>>1)+1 when `div2`=1.
- R10: With `enable`=0, `scl_oe` is 0 from the next cycle on and both counters are cleared. A later enable starts a complete low phase.
- R11: `fall_stb` lasts one cycle and appears in the first cycle that `scl_oe` is 1. `rise_stb` never appears while `scl_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the clock; low releases SCL and clears the timers |
| wide_mode | input | 1 | 1 selects 9-bit counts, 0 selects 8-bit counts |
| div2 | input | 1 | 1 divides the count clock by two |
| lo_count | input | 8 | Low-phase count bits 7:0 |
| hi_count | input | 8 | High-phase count bits 7:0 |
| ext_bits | input | 8 | Shared byte; bit 7 is low-count bit 8, bit 6 is high-count bit 8 |
| scl_in | input | 1 | Sensed SCL level, already synchronised |
| scl_oe | output | 1 | 1 pulls SCL low |
| fall_stb | output | 1 | One-cycle pulse at the start of a low phase |
| rise_stb | output | 1 | One-cycle pulse at the start of a high phase |
| mid_stb | output | 1 | One-cycle pulse at the middle of a high phase |

## Verification
With a high count of one and no divider, the first tick of the high phase is also its middle tick. The mid-phase strobe therefore fires in the same cycle as the rising-edge strobe, and the falling-edge strobe follows in the next cycle. The sweep includes high counts of 0 and 1 together with both divider settings. For each configuration, the bench measures the offset from the rising strobe to the mid strobe and the offset to the next falling strobe, and compares them with the arithmetic values. A design that misses the coincidence, or that handles the coincident tick twice, shows up as a wrong offset or a missing strobe.

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
  parameter int LO_EXT_BIT = 7,
  parameter int HI_EXT_BIT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       wide_mode,
  input  logic       div2,
  input  logic [7:0] lo_count,
  input  logic [7:0] hi_count,
  input  logic [7:0] ext_bits,
  input  logic       scl_in,
  output logic       scl_oe,
  output logic       fall_stb,
  output logic       rise_stb,
  output logic       mid_stb
);
  localparam int CW = 9;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_WAIT, S_HIGH} st_t;
  st_t st, nx;

  logic [CW-1:0] cnt, lo_raw, hi_raw, lo_lim, hi_lim, lim;
  logic pre, tick, last;

  assign lo_raw = {wide_mode & ext_bits[LO_EXT_BIT], lo_count};
  assign hi_raw = {wide_mode & ext_bits[HI_EXT_BIT], hi_count};
  assign lo_lim = (lo_raw == '0) ? CW'(1) : lo_raw;
  assign hi_lim = (hi_raw == '0) ? CW'(1) : hi_raw;
  assign lim    = (st == S_HIGH) ? hi_lim : lo_lim;
  assign tick   = div2 ? pre : 1'b1;
  assign last   = tick && (cnt >= lim - CW'(1));

  always_comb begin
    nx = st;
    case (st)
      S_IDLE: if (enable) nx = S_LOW;
      S_LOW:  if (!enable) nx = S_IDLE; else if (last) nx = S_WAIT;
      S_WAIT: if (!enable) nx = S_IDLE; else if (scl_in) nx = S_HIGH;
      S_HIGH: if (!enable) nx = S_IDLE; else if (last) nx = S_LOW;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      pre      <= 1'b0;
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
    end else begin
      st       <= nx;
      fall_stb <= (nx == S_LOW)  && (st != S_LOW);
      rise_stb <= (nx == S_HIGH) && (st != S_HIGH);
      if (nx != st || nx == S_IDLE || nx == S_WAIT) begin
        cnt <= '0;
        pre <= 1'b0;
      end else begin
        pre <= ~pre;
        if (tick) cnt <= cnt + CW'(1);
      end
    end
  end

  assign scl_oe  = (st == S_LOW);
  assign mid_stb = (st == S_HIGH) && tick && (cnt == (hi_lim >> 1));

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !scl_oe && !fall_stb && !rise_stb);
  p_rise_after_sense_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> $past(scl_in));
  p_release_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_oe);
  p_fall_with_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> fall_stb);
  p_fall_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb);
  p_rise_not_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> !scl_oe);
  p_mid_in_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mid_stb |-> !scl_oe && !fall_stb);
endmodule

// File: tb/scl_period_gen_test.sv
module scl_period_gen_test;
  logic clk = 0, rst_n = 0, enable = 0, wide_mode = 0, div2 = 0, scl_in = 1;
  logic [7:0] lo_count = 0, hi_count = 0, ext_bits = 0;
  logic scl_oe, fall_stb, rise_stb, mid_stb;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  scl_period_gen uut (.clk(clk), .rst_n(rst_n), .enable(enable), .wide_mode(wide_mode),
    .div2(div2), .lo_count(lo_count), .hi_count(hi_count), .ext_bits(ext_bits),
    .scl_in(scl_in), .scl_oe(scl_oe), .fall_stb(fall_stb), .rise_stb(rise_stb),
    .mid_stb(mid_stb));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [8:0] v, input logic w);
    int x = w ? int'(v) : int'(v[7:0]);
    return (x == 0) ? 1 : x;
  endfunction

  task automatic run(input logic [8:0] lo9, input logic [8:0] hi9, input logic w,
                     input logic d, input int s);
    int t = 0, tf = 0, tf2 = 0, tr = -1, tm = -1, trel = 0, nfall = 0;
    int m = d ? 2 : 1;
    int L = eff(lo9, w), H = eff(hi9, w);
    int midx = d ? 2 * (H >> 1) + 1 : (H >> 1);
    logic oe_prev = 0;
    lo_count = lo9[7:0]; hi_count = hi9[7:0];
    ext_bits = {lo9[8], hi9[8], 6'b101101};
    wide_mode = w; div2 = d; enable = 1;
    while (nfall < 2 && t < 5000) begin
      @(negedge clk);
      t++;
      if (fall_stb) begin
        chk(scl_oe, "R11 fall strobe with low", int'(scl_oe), 1);
        nfall++;
        if (nfall == 1) tf = t; else tf2 = t;
      end
      if (rise_stb) begin
        chk(!scl_oe, "R11 rise strobe while low", int'(scl_oe), 0);
        tr = t;
      end
      if (mid_stb && nfall == 1 && tm < 0) tm = t;
      if (!scl_oe && oe_prev) trel = t;
      if (scl_oe) scl_in = 0;
      else if (nfall >= 1) scl_in = ((t - trel) >= s);
      oe_prev = scl_oe;
    end
    chk(nfall == 2, "R2 phase sequence completes", nfall, 2);
    chk(trel - tf == L * m, (d ? "R2 R8 low length" : (L == 1 ? "R2 R7 low length" : "R2 R5 R6 low length")),
        trel - tf, L * m);
    chk(tr - trel == s + 1, "R3 wait for sensed high", tr - trel, s + 1);
    chk(tm - tr == midx, "R9 mid strobe offset", tm - tr, midx);
    chk(tf2 - tr == H * m, (d ? "R4 R8 high length" : "R4 R5 R6 R7 high length"), tf2 - tr, H * m);
    enable = 0;
    @(negedge clk);
    chk(!scl_oe && !fall_stb, "R10 release on disable", int'(scl_oe), 0);
    scl_in = 1;
    @(negedge clk);
  endtask

  initial begin
    #1520000;
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int los[9] = '{0, 1, 2, 3, 7, 255, 256, 300, 511};
    int his[6] = '{0, 1, 2, 5, 256, 511};
    repeat (3) @(negedge clk);
    chk(!scl_oe && !fall_stb && !rise_stb && !mid_stb, "R1 reset quiet", int'(scl_oe), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!scl_oe && !fall_stb && !rise_stb && !mid_stb, "R1 idle after reset", int'(scl_oe), 0);
    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 2; d++)
        for (int i = 0; i < 9; i++)
          for (int j = 0; j < 6; j++)
            run(9'(los[i]), 9'(his[j]), w[0], d[0], (i + j) % 4);
    lo_count = 8'd100; hi_count = 8'd4; wide_mode = 0; div2 = 0; enable = 1;
    repeat (10) @(negedge clk);
    enable = 0;
    @(negedge clk);
    chk(!scl_oe, "R10 abort mid low", int'(scl_oe), 0);
    repeat (3) begin
      @(negedge clk);
      chk(!scl_oe && !fall_stb && !rise_stb, "R10 stays idle", int'(scl_oe), 0);
    end
    run(9'd100, 9'd4, 1'b0, 1'b0, 2);
    run(9'd37, 9'd9, 1'b1, 1'b1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule